// File: doc/BRIEF.md
# Indexed Effective Address Calculator

This block forms a 32-bit memory operand address from a full-format indexing extension word. Each request supplies the extension word, the value of the chosen base address register, the whole register file (eight data and eight address registers) from which the index is picked, and a base displacement that is either 16 or 32 bits wide. The address is the sum of the base, the displacement and the scaled index. The base and the index can each be removed from the sum on their own, so any single register can act as the only register term.

When the extension word asks for a memory-indirect access, the computed sum is the address of a pointer, not of the operand. The block then raises a fetch request and presents the pointer address. It waits for the fetched pointer and returns that pointer as the final operand address with a one-cycle done pulse. Scaling is a plain shift in the same cycle as the sum, so it costs no extra cycle.

Top module: `idx_ea_unit`

## Requirements
- R1: Extension bit 7 set removes the base register from the sum: the base contributes zero.
- R2: Extension bit 6 set removes the index term from the sum.
- R3: Extension bit 15 picks the index register class (0 data, 1 address) and bits 14:12 its number. In `regs_flat`, data register n occupies bits [32n+31:32n] and address register n occupies bits [256+32n+31:256+32n].
- R4: Extension bit 11 picks the index size: 0 sign-extends the low 16 bits of the register to 32 bits, 1 uses all 32 bits.
- R5: Extension bits 10:9 shift the index left by 0, 1, 2 or 3 places (multiply by 1, 2, 4, 8). Code 00 means a scale of 1.
- R6: Extension bit 4 picks the displacement size: 0 sign-extends `disp[15:0]`, 1 uses all 32 bits of `disp`.
- R7: The address is base + displacement + scaled index modulo 2^32. Carries out of bit 31 are dropped.
- R8: With extension bit 0 clear, a `start` accepted while idle gives `done` high and `ea_out` equal to the address on the next cycle, with `fetch_req` staying low.
- R9: With extension bit 0 set, the cycle after `start` raises `fetch_req` with `ea_out` holding the pointer address. Both hold until `ptr_valid`. On the cycle after `ptr_valid`, `done` is high, `fetch_req` is low and `ea_out` equals the `ptr_data` that came with it.
- R10: A `start` that arrives while a pointer fetch is pending is ignored: `fetch_req` and `ea_out` do not change.
- R11: During reset `done` and `fetch_req` are low and `ea_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request strobe, sampled while idle |
| ext_word | input | 16 | Full-format indexing extension word |
| base_val | input | 32 | Value of the chosen base address register |
| disp | input | 32 | Base displacement (low half used when word-sized) |
| regs_flat | input | 512 | Eight data then eight address registers, 32 bits each |
| ptr_valid | input | 1 | Fetched pointer is on `ptr_data` |
| ptr_data | input | 32 | Fetched pointer value |
| fetch_req | output | 1 | Pointer fetch wanted at `ea_out` |
| ea_out | output | 32 | Pointer address while fetching, else the operand address |
| done | output | 1 | Operand address valid on `ea_out` this cycle |

## Verification
The bench builds the block with its default 32-bit address width, so the 16-bit sign extensions of both index and displacement fall at bit 15. Wrap-around past 2^32 can then be reached with a base near the top of memory. All sixteen register slots are filled with distinct values, some with bit 15 set, so a wrong class bit, register number or extension polarity changes the sum. The indirect path is held waiting over several cycles while a competing request arrives, and direct requests are issued back to back.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int NREG = 8;
  localparam int HW   = 16;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ea_state_e;

  typedef struct packed {
    logic       idx_addr;
    logic [2:0] idx_num;
    logic       idx_long;
    logic [1:0] scale;
    logic       rsv_a;
    logic       base_sup;
    logic       idx_sup;
    logic       rsv_b;
    logic       disp_long;
    logic [2:0] rsv_c;
    logic       indirect;
  } ext_word_t;
endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/ea_index_sel.sv
module ea_index_sel #(
  parameter int AW   = 32,
  parameter int NREG = 8
) (
  input  logic [2*NREG*AW-1:0]      regs_flat,
  input  logic                      idx_addr,
  input  logic [$clog2(NREG)-1:0]   idx_num,
  input  logic                      idx_long,
  input  logic [1:0]                scale,
  output logic [AW-1:0]             idx_term
);
  localparam int HW    = ea_pkg::HW;
  localparam int SEL_W = $clog2(NREG) + 1;

  logic [AW-1:0]    rf [2*NREG];
  logic [SEL_W-1:0] sel;
  logic [AW-1:0]    picked;
  logic [AW-1:0]    sized;

  for (genvar g = 0; g < 2*NREG; g++) begin : g_unpack
    assign rf[g] = regs_flat[g*AW +: AW];
  end

  assign sel    = {idx_addr, idx_num};
  assign picked = rf[sel];

  always_comb begin
    if (idx_long) sized = picked;
    else          sized = {{(AW-HW){picked[HW-1]}}, picked[HW-1:0]};
    idx_term = sized << scale;
  end
endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] idx_term,
  input  logic          base_sup,
  input  logic          idx_sup,
  input  logic          disp_long,
  output logic [AW-1:0] sum
);
  localparam int HW = ea_pkg::HW;

  logic [AW-1:0] base_t;
  logic [AW-1:0] disp_t;
  logic [AW-1:0] idx_t;

  always_comb begin
    base_t = base_sup  ? '0 : base_val;
    idx_t  = idx_sup   ? '0 : idx_term;
    disp_t = disp_long ? disp : {{(AW-HW){disp[HW-1]}}, disp[HW-1:0]};
    sum    = base_t + disp_t + idx_t;
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic indirect,
  input  logic ptr_valid,
  output logic fetch_req,
  output logic load_sum,
  output logic load_ptr,
  output logic done_d
);
  import ea_pkg::*;

  ea_state_e state_q;
  ea_state_e state_d;

  always_comb begin
    state_d  = state_q;
    load_sum = 1'b0;
    load_ptr = 1'b0;
    done_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_sum = 1'b1;
          if (indirect) state_d = ST_WAIT;
          else          done_d  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (ptr_valid) begin
          load_ptr = 1'b1;
          done_d   = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign fetch_req = (state_q == ST_WAIT);
endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit #(
  parameter int AW = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [15:0]                    ext_word,
  input  logic [AW-1:0]                  base_val,
  input  logic [AW-1:0]                  disp,
  input  logic [2*ea_pkg::NREG*AW-1:0]   regs_flat,
  input  logic                           ptr_valid,
  input  logic [AW-1:0]                  ptr_data,
  output logic                           fetch_req,
  output logic [AW-1:0]                  ea_out,
  output logic                           done
);
  import ea_pkg::*;

  ext_word_t ext;
  logic      rst_sync_n;
  logic [AW-1:0] idx_term;
  logic [AW-1:0] sum;
  logic load_sum, load_ptr, done_d;
  logic [AW-1:0] ea_q;
  logic [AW-1:0] ea_d;
  logic          ea_en;
  logic          done_q;
  logic [4:0]    unused_rsv;

  assign ext        = ext_word_t'(ext_word);
  assign unused_rsv = {ext.rsv_a, ext.rsv_b, ext.rsv_c};

  ea_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  ea_index_sel #(.AW(AW), .NREG(NREG)) u_idx (
    .regs_flat (regs_flat),
    .idx_addr  (ext.idx_addr),
    .idx_num   (ext.idx_num),
    .idx_long  (ext.idx_long),
    .scale     (ext.scale),
    .idx_term  (idx_term)
  );

  ea_sum #(.AW(AW)) u_sum (
    .base_val  (base_val),
    .disp      (disp),
    .idx_term  (idx_term),
    .base_sup  (ext.base_sup),
    .idx_sup   (ext.idx_sup),
    .disp_long (ext.disp_long),
    .sum       (sum)
  );

  ea_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .indirect  (ext.indirect),
    .ptr_valid (ptr_valid),
    .fetch_req (fetch_req),
    .load_sum  (load_sum),
    .load_ptr  (load_ptr),
    .done_d    (done_d)
  );

  always_comb begin
    ea_en = load_sum | load_ptr;
    ea_d  = load_ptr ? ptr_data : sum;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ea_q   <= '0;
      done_q <= 1'b0;
    end else begin
      if (ea_en) ea_q <= ea_d;
      done_q <= done_d;
    end
  end

  assign ea_out = ea_q;
  assign done   = done_q;
endmodule

// File: rtl/ea_chk.sv
module ea_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [15:0]   ext_word,
  input logic [AW-1:0] disp,
  input logic          ptr_valid,
  input logic [AW-1:0] ptr_data,
  input logic          fetch_req,
  input logic [AW-1:0] ea_out,
  input logic          done
);
  assert_no_done_while_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fetch_req));

  assert_fetch_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !ptr_valid) |=> (fetch_req && $stable(ea_out) && !done));

  assert_ptr_returned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && ptr_valid) |=> (done && !fetch_req && ea_out == $past(ptr_data)));

  assert_direct_next_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !fetch_req && !ext_word[0]) |=> (done && !fetch_req));

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !ptr_valid && start) |=> fetch_req);

  assert_disp_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !fetch_req && ext_word[7] && ext_word[6] && ext_word[4] && !ext_word[0])
    |=> (ea_out == $past(disp)));
endmodule

bind idx_ea_unit ea_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .ext_word  (ext_word),
  .disp      (disp),
  .ptr_valid (ptr_valid),
  .ptr_data  (ptr_data),
  .fetch_req (fetch_req),
  .ea_out    (ea_out),
  .done      (done)
);

// File: tb/idx_ea_unit_tb.sv
module idx_ea_unit_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [15:0]   ext_word = '0;
  logic [AW-1:0] base_val = '0;
  logic [AW-1:0] disp = '0;
  logic [16*AW-1:0] regs_flat;
  logic          ptr_valid = 1'b0;
  logic [AW-1:0] ptr_data = '0;
  logic          fetch_req;
  logic [AW-1:0] ea_out;
  logic          done;

  logic [AW-1:0] rf [16];
  logic [AW-1:0] exp_q [$];
  string         tag_q [$];
  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  idx_ea_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_word(ext_word),
    .base_val(base_val), .disp(disp), .regs_flat(regs_flat),
    .ptr_valid(ptr_valid), .ptr_data(ptr_data),
    .fetch_req(fetch_req), .ea_out(ea_out), .done(done)
  );

  initial begin
    for (int i = 0; i < 16; i++) begin
      rf[i] = 32'h0101_0000 * (i + 1) + ((i % 2 == 1) ? (32'h8000 + i * 16) : (i * 16 + 4));
      regs_flat[i*AW +: AW] = rf[i];
    end
  end

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(bit a, int n, bit lng, int sc, bit bs, bit is, bit dl, bit ind);
    logic [15:0] w = '0;
    w[15] = a; w[14:12] = 3'(n); w[11] = lng; w[10:9] = 2'(sc);
    w[7] = bs; w[6] = is; w[4] = dl; w[0] = ind;
    return w;
  endfunction

  function automatic logic [AW-1:0] model(logic [15:0] w, logic [AW-1:0] b, logic [AW-1:0] d);
    logic [AW-1:0] r, ix, bb, dd;
    r  = rf[{w[15], w[14:12]}];
    ix = w[11] ? r : {{16{r[15]}}, r[15:0]};
    ix = ix << w[10:9];
    if (w[6]) ix = '0;
    bb = w[7] ? '0 : b;
    dd = w[4] ? d : {{16{d[15]}}, d[15:0]};
    return bb + dd + ix;
  endfunction

  // called at a negedge; returns at the next negedge
  task automatic issue(logic [15:0] w, logic [AW-1:0] b, logic [AW-1:0] d, string tag);
    ext_word = w; base_val = b; disp = d; start = 1'b1;
    exp_q.push_back(model(w, b, d));
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: compares every done against the scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8/R9: unexpected done, actual %h expected none", ea_out);
      end else begin
        automatic logic [AW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, ea_out, e);
        chk({t, " fetch_req low with done"}, {31'd0, fetch_req}, 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] paddr;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 done", {31'd0, done}, 32'd0);
    chk("R11 fetch_req", {31'd0, fetch_req}, 32'd0);
    chk("R11 ea_out", ea_out, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3/R4/R5/R7 various index forms, R8 direct timing
    issue(mk(0, 2, 0, 0, 0, 0, 0, 0), 32'h0000_4000, 32'h0000_0010, "R3 R4 data word scale1");
    chk("R8 no fetch on direct", {31'd0, fetch_req}, 32'd0);
    issue(mk(0, 5, 1, 2, 0, 0, 0, 0), 32'h1000_0000, 32'h0000_0100, "R4 R5 data long scale4");
    issue(mk(1, 3, 0, 3, 0, 0, 0, 0), 32'h2000_0000, 32'h0000_0020, "R3 R4 R5 addr word neg scale8");
    issue(mk(1, 6, 1, 1, 0, 0, 1, 0), 32'h0000_0100, 32'h1234_5678, "R5 R6 addr long scale2 disp long");
    // R1 base suppressed
    issue(mk(0, 7, 1, 0, 1, 0, 0, 0), 32'hDEAD_BEEF, 32'h0000_0040, "R1 base suppressed");
    // R2 index suppressed
    issue(mk(1, 1, 1, 3, 0, 1, 1, 0), 32'h0000_8000, 32'h0001_0000, "R2 index suppressed");
    // R1/R2 both suppressed: displacement only
    issue(mk(0, 0, 0, 0, 1, 1, 1, 0), 32'hFFFF_FFFF, 32'hCAFE_0000, "R1 R2 disp only");
    // R6 word displacement sign extension
    issue(mk(0, 4, 1, 0, 0, 1, 0, 0), 32'h0000_1000, 32'h1234_FFF0, "R6 word disp negative");
    // R7 wrap past 2^32
    issue(mk(0, 0, 0, 0, 0, 1, 1, 0), 32'hFFFF_FFF0, 32'h0000_0020, "R7 wrap");
    chk("R7 model wrap value", model(mk(0, 0, 0, 0, 0, 1, 1, 0), 32'hFFFF_FFF0, 32'h20), 32'h0000_0010);
    repeat (2) @(negedge clk);

    // R9 indirect with suppressed index
    paddr = model(mk(1, 2, 0, 0, 0, 1, 0, 1), 32'h0040_0000, 32'h0000_0008);
    ext_word = mk(1, 2, 0, 0, 0, 1, 0, 1); base_val = 32'h0040_0000; disp = 32'h0000_0008;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 fetch_req raised", {31'd0, fetch_req}, 32'd1);
    chk("R9 pointer address", ea_out, paddr);
    chk("R9 no done while fetching", {31'd0, done}, 32'd0);
    @(negedge clk);
    // R10 competing start while waiting
    ext_word = mk(0, 1, 1, 0, 0, 0, 1, 0); base_val = 32'h7777_0000; disp = 32'h1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 fetch_req held", {31'd0, fetch_req}, 32'd1);
    chk("R10 ea_out unchanged", ea_out, paddr);
    chk("R10 no done", {31'd0, done}, 32'd0);
    @(negedge clk);
    ptr_valid = 1'b1; ptr_data = 32'h00AB_CDE0;
    exp_q.push_back(32'h00AB_CDE0);
    tag_q.push_back("R9 final operand address");
    @(negedge clk);
    ptr_valid = 1'b0; ptr_data = 32'h5555_5555;
    chk("R9 fetch_req dropped", {31'd0, fetch_req}, 32'd0);
    @(negedge clk);
    chk("R9 done is a pulse", {31'd0, done}, 32'd0);
    chk("R9 ea_out kept", ea_out, 32'h00AB_CDE0);

    // R8 direct again after indirect, back to back
    issue(mk(1, 7, 0, 1, 1, 0, 0, 0), 32'h0, 32'h0000_0002, "R8 back to back a");
    issue(mk(0, 3, 1, 2, 0, 0, 1, 0), 32'h0000_0004, 32'h8000_0000, "R8 back to back b");
    repeat (3) @(negedge clk);
    chk("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);

    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule